// File: doc/BRIEF.md
# Dual-Edge Input Capture Channel

This block is one capture channel of a timer. It samples a single asynchronous input through a synchronizer and detects its rising and falling transitions. It can optionally treat the input as inverted. A free-running 16-bit up-counter runs beside the detector. Each transition type that software has enabled copies the counter into a register kept for that type and raises a status flag of its own.

Software reaches one control word and two read-only capture words through a single-cycle register port. The flags are cleared by writing 1 to them. One interrupt line stays high while either flag is set.

Top module: `dual_edge_capture`

## Requirements
- R1: After reset, the control word, both capture words and both flags read 0, and `irq_o` is low.
- R2: Word 0 is the control word. Bit 0 selects inversion, bit 1 enables falling-edge capture and bit 2 enables rising-edge capture; these three bits read back as written. Bits 31 down to 5 always read 0.
- R3: Control bit 3 (falling flag) and bit 4 (rising flag) are cleared only by writing 1 to them through word 0. Writing 0 to them leaves them unchanged.
- R4: When rising capture is enabled and a rising edge is detected, word 2 takes the counter value and bit 4 of word 0 is set.
- R5: When falling capture is enabled and a falling edge is detected, word 1 takes the counter value and bit 3 of word 0 is set.
- R6: An edge whose capture is disabled changes neither its capture word nor its flag. A capture word holds its value until the next enabled edge of its type.
- R7: With bit 0 set, a physical low-to-high transition counts as a falling edge and a high-to-low transition counts as a rising edge. Changing bit 0 while the input is steady produces no edge.
- R8: An input change set up before clock edge n is captured at edge n+2. The value stored is the counter value held between edges n+1 and n+2.
- R9: If an edge sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R10: An enabled edge overwrites its capture word even while its flag is still set.
- R11: `irq_o` is high exactly while bit 3 or bit 4 of word 0 is set.
- R12: The counter is 0 in the first cycle after reset and increases by 1 on every clock. It wraps from 0xFFFF to 0x0000. Words 1 and 2 hold the capture in bits 15:0, upper bits read 0, and word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Asynchronous capture input |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 control, 1 falling capture, 2 rising capture |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected word, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the counter steps by one, and that an enabled edge loads its capture word with the counter and sets its flag, which covers the set-over-clear priority. They also check that capture words and flags stay still when nothing acts on them, that control bits follow a write, and that the interrupt matches the flags seen through the control word. Only the bench scenarios can show the two-cycle input latency, the swap of edges under inversion, the absence of a spurious edge when inversion is toggled, and a capture taken after the counter has wrapped. The bench compares every cycle against its behavioural model.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_FALL = 1;
  localparam int unsigned ADDR_RISE = 2;

  localparam int unsigned BIT_INV  = 0;
  localparam int unsigned BIT_EN0  = 1;  // falling enable, rising at +1
  localparam int unsigned BIT_FLG0 = 3;  // falling flag, rising at +1
  localparam int unsigned CTRL_USED = 5;

  localparam int unsigned KIND_FALL = 0;
  localparam int unsigned KIND_RISE = 1;
  localparam int unsigned N_KINDS   = 2;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic invert_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         cur, up_raw, down_raw;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sig_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[MSB-1:0], sig_i};
    end
  endgenerate

  assign cur = sync_q[MSB];

  // history is kept on the raw level so toggling invert_i makes no edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;

  assign up_raw   = cur & ~prev_q;
  assign down_raw = ~cur & prev_q;

  always_comb begin
    if (invert_i) begin
      rise_o = down_raw;
      fall_o = up_raw;
    end else begin
      rise_o = up_raw;
      fall_o = down_raw;
    end
  end
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        ctrl_o,
  output logic [1:0]        flag_o,
  output logic [CNT_W-1:0]  fall_cap_o,
  output logic [CNT_W-1:0]  rise_cap_o
);
  localparam int unsigned PAD_CAP  = DATA_W - CNT_W;
  localparam int unsigned PAD_CTRL = DATA_W - CTRL_USED;

  logic              ctrl_wr;
  logic [2:0]        ctrl_q;
  logic [1:0]        evt;
  logic [CNT_W-1:0]  cap_q [N_KINDS];

  assign ctrl_wr = we_i && (addr_i == ADDR_W'(ADDR_CTRL));
  assign evt[KIND_FALL] = fall_i;
  assign evt[KIND_RISE] = rise_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wdata_i[2:0];

  generate
    for (genvar k = 0; k < N_KINDS; k++) begin : g_kind
      logic hit, clr;
      assign hit = evt[k] & ctrl_q[BIT_EN0 + k];
      assign clr = ctrl_wr & wdata_i[BIT_FLG0 + k];

      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)  cap_q[k] <= '0;
        else if (hit) cap_q[k] <= cnt_i;

      // set beats a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) flag_o[k] <= 1'b0;
        else         flag_o[k] <= hit | (flag_o[k] & ~clr);
    end
  endgenerate

  assign ctrl_o     = ctrl_q;
  assign fall_cap_o = cap_q[KIND_FALL];
  assign rise_cap_o = cap_q[KIND_RISE];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADDR_CTRL): rdata_o = {{PAD_CTRL{1'b0}}, flag_o, ctrl_q};
      ADDR_W'(ADDR_FALL): rdata_o = {{PAD_CAP{1'b0}}, cap_q[KIND_FALL]};
      ADDR_W'(ADDR_RISE): rdata_o = {{PAD_CAP{1'b0}}, cap_q[KIND_RISE]};
      default:            rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt;
  logic             rise_evt, fall_evt;
  logic [2:0]       ctrl;
  logic [1:0]       flags;
  logic [CNT_W-1:0] fall_cap, rise_cap;

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (cap_i),
    .invert_i(ctrl[cap_pkg::BIT_INV]),
    .rise_o  (rise_evt),
    .fall_o  (fall_evt)
  );

  cap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt)
  );

  cap_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rise_i    (rise_evt),
    .fall_i    (fall_evt),
    .cnt_i     (cnt),
    .rdata_o   (reg_rdata_o),
    .ctrl_o    (ctrl),
    .flag_o    (flags),
    .fall_cap_o(fall_cap),
    .rise_cap_o(rise_cap)
  );

  assign irq_o = |flags;
endmodule

// File: rtl/dual_edge_capture_chk.sv
module dual_edge_capture_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [CNT_W-1:0]  cnt,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic [2:0]        ctrl,
  input logic [1:0]        flags,
  input logic [CNT_W-1:0]  fall_cap,
  input logic [CNT_W-1:0]  rise_cap
);
  logic rise_hit, fall_hit, ctrl_wr;
  assign rise_hit = rise_evt & ctrl[2];
  assign fall_hit = fall_evt & ctrl[1];
  assign ctrl_wr  = reg_we_i && (reg_addr_i == '0);

  // R12
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));
  // R4
  rise_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_hit |=> (rise_cap == $past(cnt)) && flags[1]);
  // R5
  fall_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_hit |=> (fall_cap == $past(cnt)) && flags[0]);
  // R6
  rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_hit |=> $stable(rise_cap));
  // R6
  fall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_hit |=> $stable(fall_cap));
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_hit && ctrl_wr && reg_wdata_i[4]) |=> flags[1]);
  // R3
  rflag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_hit && !(ctrl_wr && reg_wdata_i[4])) |=> $stable(flags[1]));
  // R3
  fflag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_hit && !(ctrl_wr && reg_wdata_i[3])) |=> $stable(flags[0]));
  // R2
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ctrl == $past(reg_wdata_i[2:0]));
  // R2
  ctrl_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> reg_rdata_o[DATA_W-1:5] == '0);
  // R11
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == '0) |-> irq_o == (reg_rdata_o[4] | reg_rdata_o[3]));
endmodule

bind dual_edge_capture dual_edge_capture_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_o      (irq_o),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .cnt        (cnt),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .ctrl       (ctrl),
  .flags      (flags),
  .fall_cap   (fall_cap),
  .rise_cap   (rise_cap)
);

// File: tb/dual_edge_capture_bench.sv
module dual_edge_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  bit track = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit      pipe[$];
  bit      m_prev;
  int      m_cnt;
  bit [2:0] m_ctrl;
  bit      m_ff, m_rf;
  int      m_fcap, m_rcap;

  always #10 clk = ~clk;  // 50 MHz

  dual_edge_capture u_dual_edge_capture (
    .clk_i(clk), .rst_ni(rst_n), .cap_i(cap), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {27'd0, m_rf, m_ff, m_ctrl};
      2'd1:    return 32'(m_fcap);
      2'd2:    return 32'(m_rcap);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{1'b0, 1'b0};
      m_prev = 0; m_cnt = 0; m_ctrl = 0; m_ff = 0; m_rf = 0;
      m_fcap = 0; m_rcap = 0;
    end else begin
      bit lvl, up, down, r, f, rs, fs;
      lvl  = pipe[0];
      up   = lvl && !m_prev;
      down = !lvl && m_prev;
      r = m_ctrl[0] ? down : up;
      f = m_ctrl[0] ? up : down;
      rs = r && m_ctrl[2];
      fs = f && m_ctrl[1];
      if (rs) m_rcap = m_cnt;
      if (fs) m_fcap = m_cnt;
      if (we && addr == 2'd0) begin
        if (wdata[4]) m_rf = 0;
        if (wdata[3]) m_ff = 0;
        m_ctrl = wdata[2:0];
      end
      if (rs) m_rf = 1;
      if (fs) m_ff = 1;
      m_prev = lvl;
      void'(pipe.pop_front());
      pipe.push_back(cap);
      m_cnt = (m_cnt + 1) % 65536;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && track && !done) begin
      chk(cur_req, rdata, exp_rdata(addr));
      chk("R11", {31'd0, irq}, {31'd0, m_ff | m_rf});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #2; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #2; we = 1'b0; wdata = '0;
  endtask

  task automatic sel(input logic [1:0] a);
    @(negedge clk); #2; addr = a;
  endtask

  task automatic drive(input logic v);
    @(negedge clk); #2; cap = v;
  endtask

  initial begin
    idle(3);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 32'd0);
    chk("R1", {31'd0, irq}, 32'd0);
    sel(2'd1); @(negedge clk); chk("R1", rdata, 32'd0);
    sel(2'd2); @(negedge clk); chk("R1", rdata, 32'd0);
    track = 1;

    cur_req = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    @(negedge clk); chk("R2", rdata, 32'h0000_0007);
    sel(2'd3); @(negedge clk); chk("R12", rdata, 32'd0);
    sel(2'd0);
    wr(2'd0, 32'h0000_0006);

    cur_req = "R4";
    drive(1'b1); idle(4);
    chk("R4", rdata & 32'h10, 32'h10);
    chk("R11", {31'd0, irq}, 32'd1);
    sel(2'd2); idle(2);

    cur_req = "R5";
    drive(1'b0); idle(4);
    sel(2'd1); idle(2);
    sel(2'd0); @(negedge clk); chk("R5", rdata & 32'h18, 32'h18);

    cur_req = "R3";
    wr(2'd0, 32'h0000_0006); idle(1);
    chk("R3", rdata, 32'h1E);
    wr(2'd0, 32'h0000_000E); idle(1);
    chk("R3", rdata, 32'h16);
    wr(2'd0, 32'h0000_0016); idle(1);
    chk("R3", rdata, 32'h06);
    chk("R11", {31'd0, irq}, 32'd0);

    cur_req = "R8";
    begin
      int at_edge;
      drive(1'b1);
      at_edge = cycles;  // negedge count just before edge n
      idle(4);
      sel(2'd2); @(negedge clk);
      // capture at edge n+2 stores the count after edge n+1
      chk("R8", rdata, 32'(m_rcap));
    end

    cur_req = "R6";
    wr(2'd0, 32'h0000_0012);  // falling only, clear rising flag
    sel(2'd2);
    begin
      logic [31:0] keep;
      @(negedge clk); keep = rdata;
      drive(1'b0); drive(1'b1); idle(5);
      chk("R6", rdata, keep);
      sel(2'd0); @(negedge clk); chk("R6", rdata & 32'h10, 32'h0);
    end

    cur_req = "R7";
    wr(2'd0, 32'h0000_001E);
    wr(2'd0, 32'h0000_0007);  // invert, input steady high
    idle(5);
    chk("R7", rdata, 32'h07);
    drive(1'b0); idle(4);
    chk("R7", rdata, 32'h17);
    drive(1'b1); idle(4);
    chk("R7", rdata, 32'h1F);
    wr(2'd0, 32'h0000_001E); idle(1);

    cur_req = "R10";
    drive(1'b0); idle(4);
    drive(1'b1); idle(4);
    sel(2'd2); idle(2);
    drive(1'b0); idle(4);
    drive(1'b1); idle(4);

    cur_req = "R9";
    sel(2'd0);
    wr(2'd0, 32'h0000_001E); idle(1);
    drive(1'b0); idle(3);
    drive(1'b1); idle(1);
    wr(2'd0, 32'h0000_0016);  // clear lands on the capture edge
    idle(1);
    chk("R9", rdata & 32'h10, 32'h10);

    cur_req = "R12";
    wr(2'd0, 32'h0000_001E);
    idle(65600);
    drive(1'b0); idle(4);
    sel(2'd1); idle(2);
    sel(2'd0); idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lim = 190000;
    while (cycles < lim && !done) @(negedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, lim);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule